// File: doc/BRIEF.md
# Row-Parallel Line Staging Buffer

This block sits between a wide array of per-lane memories and a narrow external memory port. It holds one image row of 128 lanes of 8 bits, split into sixteen 64-bit registers, each covering eight adjacent lanes. The array side sees the whole row in a single memory cycle. The external side sees the row as sixteen 64-bit words, one per cycle, on consecutive cycles. The lane array keeps running while these words move, so it pays only the single memory cycle for each row.

A transfer starts with a one-cycle request and a direction bit. In the outbound direction (array to external), the row is captured from the lane memories in the cycle the request is accepted. It is then streamed out. In the inbound direction (external to array), sixteen words are taken in first. The assembled row is then written to the lane memories in one cycle. While a transfer is in progress the block reports busy and refuses new requests. A one-cycle done pulse marks the end of each transfer.

Top module: `line_stage_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, extOutValid, extInTake, memRdEn and memWrEn are all 0.
- R2: A request with rowDir=0 (outbound) is accepted in a cycle where busy is 0. In that same cycle, memRdEn is 1 for exactly one cycle and rowIn is captured. A rejected request never raises memRdEn.
- R3: After an accepted outbound request, extOutValid is 1 for exactly 16 consecutive cycles, beginning in the next cycle.
- R4: The k-th outbound word (k=0 first) holds lanes 8k to 8k+7. Lane L is taken from rowIn bits [8L+7:8L], and within the word the lowest lane sits in bits [7:0].
- R5: After an accepted request with rowDir=1 (inbound), extInTake is 1 for exactly 16 consecutive cycles, beginning in the next cycle. extInData is sampled at the end of each of those cycles.
- R6: In the cycle after the 16th inbound word, memWrEn is 1 for exactly one cycle. In that cycle, rowOut bits [64k+63:64k] equal the k-th word taken in.
- R7: busy is 1 from the cycle after acceptance until the last stream cycle (outbound) or the write cycle (inbound). Requests made while busy have no effect on any output.
- R8: done is a one-cycle pulse in the cycle after a transfer's last cycle. busy is 0 in that cycle, and a request made then is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowReq | input | 1 | Transfer request |
| rowDir | input | 1 | 0 outbound (array to external), 1 inbound |
| rowIn | input | 1024 | Row read from lane memories; lane L at bits [8L+7:8L] |
| memRdEn | output | 1 | Lane memories read for capture this cycle |
| memWrEn | output | 1 | Lane memories written with rowOut this cycle |
| rowOut | output | 1024 | Row assembled from inbound words |
| extOutValid | output | 1 | extOutData carries an outbound word |
| extOutData | output | 64 | Outbound word |
| extInTake | output | 1 | extInData is sampled at the end of this cycle |
| extInData | input | 64 | Inbound word |
| busy | output | 1 | Transfer in progress; requests refused |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach from the ports is the boundary between transfers. One such point is the write cycle of an inbound transfer, where a request must still be refused. The other is the done cycle that follows, where the same request must be taken. The stimulus holds rowReq high without a break through whole transfers, in both directions and with the direction alternating. This makes every transfer end at exactly one of these edges. A behavioural model built on a word queue predicts every output on every cycle, including the word order of each stream.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_RECV  = 2'd2,
    ST_WRITE = 2'd3
  } stageState_e;

  // strobes from the sequencer to the register bank
  typedef struct packed {
    logic capture;
    logic shiftOut;
    logic shiftIn;
  } stageStrobes_t;

endpackage

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int NUM_GROUPS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rowReq,
  input  logic          rowDir,
  output stageStrobes_t strobes,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic          extOutValid,
  output logic          extInTake,
  output logic          busy,
  output logic          done
);

  localparam int CNT_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_GROUPS - 1);

  stageState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic doneQ, doneD;
  logic accept;
  logic lastWord;

  assign accept   = rowReq && (stateQ == ST_IDLE);
  assign lastWord = (cntQ == LAST_IDX);

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        cntD = '0;
        if (accept) stateD = rowDir ? ST_RECV : ST_SEND;
      end
      ST_SEND: begin
        cntD = cntQ + 1'b1;
        if (lastWord) begin
          stateD = ST_IDLE;
          cntD   = '0;
          doneD  = 1'b1;
        end
      end
      ST_RECV: begin
        cntD = cntQ + 1'b1;
        if (lastWord) begin
          stateD = ST_WRITE;
          cntD   = '0;
        end
      end
      ST_WRITE: begin
        stateD = ST_IDLE;
        doneD  = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      doneQ  <= doneD;
    end
  end

  assign memRdEn     = accept && !rowDir;
  assign memWrEn     = (stateQ == ST_WRITE);
  assign extOutValid = (stateQ == ST_SEND);
  assign extInTake   = (stateQ == ST_RECV);
  assign busy        = (stateQ != ST_IDLE);
  assign done        = doneQ;

  assign strobes.capture  = memRdEn;
  assign strobes.shiftOut = extOutValid;
  assign strobes.shiftIn  = extInTake;

endmodule

// File: rtl/rowbuf_datapath.sv
module rowbuf_datapath
  import rowbuf_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int WORD_W     = 64,
  localparam int ROW_W     = NUM_GROUPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stageStrobes_t     strobes,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [WORD_W-1:0] extInData,
  output logic [ROW_W-1:0]  rowOut,
  output logic [WORD_W-1:0] extOutData
);

  logic [WORD_W-1:0] grp [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
    logic [WORD_W-1:0] feed;
    if (g == NUM_GROUPS - 1) begin : gen_tail
      assign feed = strobes.shiftIn ? extInData : '0;
    end else begin : gen_body
      assign feed = grp[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp[g] <= '0;
      end else if (strobes.capture) begin
        grp[g] <= rowIn[g*WORD_W +: WORD_W];
      end else if (strobes.shiftOut || strobes.shiftIn) begin
        grp[g] <= feed;
      end
    end

    assign rowOut[g*WORD_W +: WORD_W] = grp[g];
  end

  assign extOutData = grp[0];

endmodule

// File: rtl/line_stage_buffer.sv
module line_stage_buffer
  import rowbuf_pkg::*;
#(
  parameter int NUM_GROUPS      = 16,
  parameter int LANES_PER_GROUP = 8,
  parameter int LANE_W          = 8,
  localparam int WORD_W         = LANES_PER_GROUP * LANE_W,
  localparam int ROW_W          = NUM_GROUPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rowReq,
  input  logic              rowDir,
  input  logic [ROW_W-1:0]  rowIn,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ROW_W-1:0]  rowOut,
  output logic              extOutValid,
  output logic [WORD_W-1:0] extOutData,
  output logic              extInTake,
  input  logic [WORD_W-1:0] extInData,
  output logic              busy,
  output logic              done
);

  stageStrobes_t strobes;

  rowbuf_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rowReq     (rowReq),
    .rowDir     (rowDir),
    .strobes    (strobes),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn),
    .extOutValid(extOutValid),
    .extInTake  (extInTake),
    .busy       (busy),
    .done       (done)
  );

  rowbuf_datapath #(.NUM_GROUPS(NUM_GROUPS), .WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .rowIn     (rowIn),
    .extInData (extInData),
    .rowOut    (rowOut),
    .extOutData(extOutData)
  );

endmodule

// File: rtl/rowbuf_checker.sv
module rowbuf_checker #(
  parameter int NUM_GROUPS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rowReq,
  input logic memRdEn,
  input logic memWrEn,
  input logic extOutValid,
  input logic extInTake,
  input logic busy,
  input logic done
);

  localparam int RUN_W = $clog2(NUM_GROUPS + 1) + 1;

  logic [RUN_W-1:0] outRun, inRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outRun <= '0;
      inRun  <= '0;
    end else begin
      outRun <= extOutValid ? outRun + 1'b1 : '0;
      inRun  <= extInTake   ? inRun  + 1'b1 : '0;
    end
  end

  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> !memRdEn);

  assert_stream_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(extOutValid) |-> $past(memRdEn));

  assert_stream_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!extOutValid && outRun != '0) |-> (outRun == RUN_W'(NUM_GROUPS)));

  assert_take_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!extInTake && inRun != '0) |-> (inRun == RUN_W'(NUM_GROUPS)));

  assert_write_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> $past(extInTake));

  assert_write_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |=> !memWrEn);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(extOutValid && extInTake));

  assert_busy_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rowReq));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind line_stage_buffer rowbuf_checker #(.NUM_GROUPS(NUM_GROUPS)) u_rowbuf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rowReq     (rowReq),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .extOutValid(extOutValid),
  .extInTake  (extInTake),
  .busy       (busy),
  .done       (done)
);

// File: tb/line_stage_buffer_bench.sv
module line_stage_buffer_bench;

  localparam int GROUPS = 16;
  localparam int WW     = 64;
  localparam int RW     = GROUPS * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rowReq = 1'b0;
  logic          rowDir = 1'b0;
  logic [RW-1:0] rowIn = '0;
  logic [WW-1:0] extInData = '0;
  logic          memRdEn, memWrEn, extOutValid, extInTake, busy, done;
  logic [RW-1:0] rowOut;
  logic [WW-1:0] extOutData;

  int checks = 0;
  int errors = 0;

  // reference model state: 0 idle, 1 send, 2 receive, 3 write
  int            mState = 0;
  logic [WW-1:0] mQ[$];
  logic          mDone = 1'b0;

  always #4 clk = ~clk;

  line_stage_buffer u_line_stage_buffer (
    .clk(clk), .rst_n(rst_n), .rowReq(rowReq), .rowDir(rowDir), .rowIn(rowIn),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .rowOut(rowOut),
    .extOutValid(extOutValid), .extOutData(extOutData),
    .extInTake(extInTake), .extInData(extInData), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] randRow();
    logic [RW-1:0] r;
    for (int i = 0; i < RW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // one clock: drive at the falling edge, compare, advance the model
  task automatic cycle(input logic req, input logic dir, input logic [RW-1:0] row,
                       input logic [WW-1:0] win);
    bit accept;
    logic [RW-1:0] expRow;
    @(negedge clk);
    rowReq = req; rowDir = dir; rowIn = row; extInData = win;
    #1;
    accept = req && (mState == 0);
    chk(memRdEn == (accept && !dir), "R2 memRdEn", RW'(memRdEn), RW'(accept && !dir));
    chk(busy == (mState != 0), "R7 busy", RW'(busy), RW'(mState != 0));
    chk(done == mDone, "R8 done", RW'(done), RW'(mDone));
    chk(extOutValid == (mState == 1), "R3 extOutValid", RW'(extOutValid), RW'(mState == 1));
    chk(extInTake == (mState == 2), "R5 extInTake", RW'(extInTake), RW'(mState == 2));
    chk(memWrEn == (mState == 3), "R6 memWrEn", RW'(memWrEn), RW'(mState == 3));
    if (mState == 1)
      chk(extOutData == mQ[0], "R4 word order", RW'(extOutData), RW'(mQ[0]));
    if (mState == 3) begin
      for (int k = 0; k < GROUPS; k++) expRow[k*WW +: WW] = mQ[k];
      chk(rowOut == expRow, "R6 rowOut", rowOut, expRow);
    end
    mDone = 1'b0;
    case (mState)
      0: if (accept) begin
           mQ.delete();
           if (!dir) begin
             for (int k = 0; k < GROUPS; k++) mQ.push_back(row[k*WW +: WW]);
             mState = 1;
           end else mState = 2;
         end
      1: begin
           void'(mQ.pop_front());
           if (mQ.size() == 0) begin mState = 0; mDone = 1'b1; end
         end
      2: begin
           mQ.push_back(win);
           if (mQ.size() == GROUPS) mState = 3;
         end
      default: begin mState = 0; mDone = 1'b1; mQ.delete(); end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] laneRow;
    // R1: outputs quiet in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!(busy || done || extOutValid || extInTake || memRdEn || memWrEn),
          "R1 reset outputs", RW'({busy, done, extOutValid, extInTake, memRdEn, memWrEn}), '0);
    end
    @(negedge clk); rst_n = 1'b1;
    cycle(0, 0, '0, '0);

    // R4: lane L carries value L, so word k must be lanes 8k..8k+7 low-first
    for (int l = 0; l < RW / 8; l++) laneRow[l*8 +: 8] = 8'(l);
    cycle(1, 0, laneRow, '0);
    // R7: requests of both directions during streaming are refused
    for (int i = 0; i < 15; i++) cycle(1, 1'(i % 2), randRow(), {$urandom, $urandom});
    for (int i = 0; i < 4; i++) cycle(0, 0, randRow(), '0);

    // R5/R6/R8: request held high through inbound transfers, re-accepted in done cycle
    for (int i = 0; i < 60; i++) cycle(1, 1, randRow(), {$urandom, $urandom});
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, '0);

    // R8: held request with alternating direction chains transfers back to back
    for (int i = 0; i < 120; i++) cycle(1, 1'(i / 20 % 2), randRow(), {$urandom, $urandom});

    // random traffic in both directions
    for (int i = 0; i < 600; i++)
      cycle(1'($urandom % 3 == 0), 1'($urandom), randRow(), {$urandom, $urandom});

    // R4: inverted lane pattern, then drain
    for (int l = 0; l < RW / 8; l++) laneRow[l*8 +: 8] = 8'(8'hFF - 8'(l));
    for (int i = 0; i < 20; i++) cycle(0, 0, '0, '0);
    cycle(1, 0, laneRow, '0);
    for (int i = 0; i < 20; i++) cycle(0, 0, '0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule